// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block decides, for each of the two source operands of an instruction entering the execute stage, where the ALU should take its value from. The choices are the register-file read data, the result leaving the execute stage one instruction ahead (held in the execute/memory pipeline register), or the value about to be written back two instructions ahead (held in the memory/write-back pipeline register). The block compares the two source register numbers against the destination register numbers and write enables of those two older stages. It drives a 2-bit select per operand.

The same module also applies the selects to the candidate data, giving the bypassed operand values combinationally. It captures them in a pair of operand registers on each clock, so the selects can be checked against real data. A consumer three instructions behind its producer needs no path here. The register file writes in the first half of a cycle and reads in the second, so the plain register-file value is already correct for it.

Top module: `operand_bypass`

## Requirements
- R1: When `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_a_idx`, `sel_a` is 2'b10 (execute/memory result).
- R2: When `exm_wen` is 1, `exm_dst` is nonzero and `exm_dst` equals `src_b_idx`, `sel_b` is 2'b10.
- R3: When no execute/memory match applies to an operand, and `mwb_wen` is 1, `mwb_dst` is nonzero and `mwb_dst` equals that operand's source index, its select is 2'b01 (write-back value).
- R4: When both older stages match the same source index, the execute/memory stage wins and the select is 2'b10.
- R5: Register number zero is never bypassed: a source index of 0 always gives select 2'b00.
- R6: A stage whose write enable is 0 is never a bypass source, whatever its destination number.
- R7: With no qualifying match the select is 2'b00 and the operand equals the register-file data. This covers a producer three instructions back.
- R8: `op_a` and `op_b` equal `rf_a_data`/`exm_result`/`mwb_value` for selects 2'b00/2'b10/2'b01.
- R9: `op_a_q` and `op_b_q` take the values of `op_a` and `op_b` at each rising clock edge. They are zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the operand registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_a_idx | input | 5 | First source register number in execute stage |
| src_b_idx | input | 5 | Second source register number in execute stage |
| rf_a_data | input | 32 | Register-file value for the first source |
| rf_b_data | input | 32 | Register-file value for the second source |
| exm_dst | input | 5 | Destination number in the execute/memory register |
| exm_wen | input | 1 | Register-write enable in the execute/memory register |
| exm_result | input | 32 | ALU result in the execute/memory register |
| mwb_dst | input | 5 | Destination number in the memory/write-back register |
| mwb_wen | input | 1 | Register-write enable in the memory/write-back register |
| mwb_value | input | 32 | Write-back value in the memory/write-back register |
| sel_a | output | 2 | Bypass select for the first operand |
| sel_b | output | 2 | Bypass select for the second operand |
| op_a | output | 32 | Bypassed first operand |
| op_b | output | 32 | Bypassed second operand |
| op_a_q | output | 32 | Registered first operand |
| op_b_q | output | 32 | Registered second operand |

## Verification
The bench aims at cases where both older stages name the same register. A design with the priority reversed would hand the ALU a stale value from two instructions back. It drives register zero as a destination with write enable set, which a design lacking the zero check would wrongly bypass. It also sets a matching destination with its enable cleared, where a design ignoring the enable would forward from a stage that writes no register. Random traffic over a narrow range of register numbers makes matches on one operand, on both, and on neither common. Each operand is checked on its own, so a swapped source index would be caught.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_W-1:0]  src_a_idx,
  input  logic [REG_W-1:0]  src_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic              exm_wen,
  input  logic [DATA_W-1:0] exm_result,
  input  logic [REG_W-1:0]  mwb_dst,
  input  logic              mwb_wen,
  input  logic [DATA_W-1:0] mwb_value,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b,
  output logic [DATA_W-1:0] op_a_q,
  output logic [DATA_W-1:0] op_b_q
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_EXM = 2'b10;
  localparam logic [1:0] SEL_MWB = 2'b01;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exm_live, mwb_live;
  assign exm_live = exm_wen && (exm_dst != ZERO_REG);
  assign mwb_live = mwb_wen && (mwb_dst != ZERO_REG);

  function automatic logic [1:0] pick(input logic [REG_W-1:0] src);
    if (exm_live && exm_dst == src)      return SEL_EXM;
    else if (mwb_live && mwb_dst == src) return SEL_MWB;
    else                                 return SEL_RF;
  endfunction

  assign sel_a = pick(src_a_idx);
  assign sel_b = pick(src_b_idx);

  function automatic logic [DATA_W-1:0] route(input logic [1:0] s,
                                              input logic [DATA_W-1:0] rf);
    case (s)
      SEL_EXM: return exm_result;
      SEL_MWB: return mwb_value;
      default: return rf;
    endcase
  endfunction

  assign op_a = route(sel_a, rf_a_data);
  assign op_b = route(sel_b, rf_b_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a_q <= '0;
      op_b_q <= '0;
    end else begin
      op_a_q <= op_a;
      op_b_q <= op_b;
    end
  end
endmodule

// File: rtl/operand_bypass_chk.sv
module operand_bypass_chk #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  src_a_idx,
  input logic [REG_W-1:0]  src_b_idx,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [REG_W-1:0]  exm_dst,
  input logic              exm_wen,
  input logic [DATA_W-1:0] exm_result,
  input logic [REG_W-1:0]  mwb_dst,
  input logic              mwb_wen,
  input logic [DATA_W-1:0] mwb_value,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [DATA_W-1:0] op_a_q,
  input logic [DATA_W-1:0] op_b_q
);
  a_r1_exm_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_wen && exm_dst != '0 && exm_dst == src_a_idx) |-> sel_a == 2'b10);
  a_r2_exm_to_b: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_wen && exm_dst != '0 && exm_dst == src_b_idx) |-> sel_b == 2'b10);
  a_r3_mwb_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!(exm_wen && exm_dst == src_a_idx) && mwb_wen && mwb_dst != '0 &&
     mwb_dst == src_a_idx) |-> sel_a == 2'b01);
  a_r5_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_idx == '0) |-> sel_a == 2'b00);
  a_r5_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_idx == '0) |-> sel_b == 2'b00);
  a_r6_idle_stages: assert property (@(posedge clk) disable iff (!rst_n)
    (!exm_wen && !mwb_wen) |-> (sel_a == 2'b00 && sel_b == 2'b00));
  a_r8_route_a: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 2'b00 |-> op_a == rf_a_data) and
    (sel_a == 2'b10 |-> op_a == exm_result) and
    (sel_a == 2'b01 |-> op_a == mwb_value));
  a_r8_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sel_a != 2'b11 && sel_b != 2'b11);
  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (op_a_q == $past(op_a) && op_b_q == $past(op_b)));
endmodule

bind operand_bypass operand_bypass_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
  .rf_a_data(rf_a_data), .exm_dst(exm_dst), .exm_wen(exm_wen),
  .exm_result(exm_result), .mwb_dst(mwb_dst), .mwb_wen(mwb_wen),
  .mwb_value(mwb_value), .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a),
  .op_b(op_b), .op_a_q(op_a_q), .op_b_q(op_b_q)
);

// File: tb/operand_bypass_tb_top.sv
`timescale 1ns/1ps
module operand_bypass_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_a_idx = '0, src_b_idx = '0, exm_dst = '0, mwb_dst = '0;
  logic        exm_wen = 1'b0, mwb_wen = 1'b0;
  logic [31:0] rf_a_data = '0, rf_b_data = '0, exm_result = '0, mwb_value = '0;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] op_a, op_b, op_a_q, op_b_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  operand_bypass dut_i (
    .clk(clk), .rst_n(rst_n), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .rf_a_data(rf_a_data), .rf_b_data(rf_b_data), .exm_dst(exm_dst),
    .exm_wen(exm_wen), .exm_result(exm_result), .mwb_dst(mwb_dst),
    .mwb_wen(mwb_wen), .mwb_value(mwb_value), .sel_a(sel_a), .sel_b(sel_b),
    .op_a(op_a), .op_b(op_b), .op_a_q(op_a_q), .op_b_q(op_b_q)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] src);
    if (exm_wen && exm_dst != 0 && exm_dst == src) return 2'b10;
    if (mwb_wen && mwb_dst != 0 && mwb_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] exp_op(input logic [1:0] s, input logic [31:0] rf);
    return (s == 2'b10) ? exm_result : (s == 2'b01) ? mwb_value : rf;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] ed, input logic ew,
                       input logic [4:0] md, input logic mw, input string req);
    logic [1:0] ea, eb;
    logic [31:0] qa, qb;
    @(negedge clk);
    src_a_idx = sa; src_b_idx = sb; exm_dst = ed; exm_wen = ew;
    mwb_dst = md; mwb_wen = mw;
    rf_a_data = $urandom; rf_b_data = $urandom;
    exm_result = $urandom; mwb_value = $urandom;
    #1;
    ea = exp_sel(sa); eb = exp_sel(sb);
    qa = exp_op(ea, rf_a_data); qb = exp_op(eb, rf_b_data);
    check({req, " sel_a"}, {30'd0, sel_a}, {30'd0, ea});
    check({req, " sel_b"}, {30'd0, sel_b}, {30'd0, eb});
    check({req, " R8 op_a"}, op_a, qa);
    check({req, " R8 op_b"}, op_b, qb);
    @(posedge clk); #1;
    check("R9 op_a_q", op_a_q, qa);
    check("R9 op_b_q", op_b_q, qb);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0330));
    #1;
    check("R9 reset op_a_q", op_a_q, 32'd0);
    check("R9 reset op_b_q", op_b_q, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset hold", op_a_q | op_b_q, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    apply(5'd2, 5'd7, 5'd2, 1, 5'd9, 1, "R1");
    apply(5'd4, 5'd2, 5'd2, 1, 5'd9, 1, "R2");
    apply(5'd6, 5'd6, 5'd1, 1, 5'd6, 1, "R3");
    apply(5'd3, 5'd3, 5'd3, 1, 5'd3, 1, "R4");
    apply(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, "R5");
    apply(5'd8, 5'd8, 5'd8, 0, 5'd8, 0, "R6");
    apply(5'd8, 5'd5, 5'd8, 0, 5'd5, 1, "R6 R3");
    apply(5'd10, 5'd11, 5'd12, 1, 5'd13, 1, "R7");
    for (int i = 0; i < 400; i++)
      apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), "R1-random R2 R3 R4 R5 R6 R7");
    finish_run();
  end
endmodule